// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block is the receive half of a serial port running as a clocked slave. An external master drives the shift clock and the data line. The block brings both into the system clock domain, finds each falling edge of the shift clock and takes one data bit there, least significant bit first. When a character of 8 or 9 bits is complete, it moves into a two-entry receive queue. Software reads the queue through a small register interface.

A receive-complete flag stays high while the queue holds data, and each read of the data register removes one entry. The ninth bit of the oldest entry can be read in the control register. If a character completes while the queue is full, an overrun is latched. The character is discarded, and shifting stops until software clears the continuous-receive enable. An interrupt request follows the receive-complete flag when the interrupt enable is set. A wake request follows it while the sleep input is high. Because the shift clock comes from outside, characters keep arriving while the core sleeps.

Register map (`addr`):
- 0, control:
  - bit 7 port enable
  - bit 6 nine-bit mode
  - bit 5 single-receive (stored, no effect)
  - bit 4 continuous receive
  - bit 3 address filter
  - bit 2 overrun (read-only)
  - bit 1 reads 0
  - bit 0 ninth bit of the oldest entry (read-only)
- 1, mode:
  - bit 0 synchronous select
  - bit 1 clock-source (master) select
  - bit 2 receive interrupt enable
- 2, data: low 8 bits of the oldest entry. A read pops that entry.
- 3, status:
  - bit 0 receive-complete
  - bit 1 interrupt request

Top module: `sync_slave_rx`

## Requirements
- R1: Characters are received only when port enable = 1, synchronous select = 1 and clock-source select = 0. In any other combination no character reaches the queue.
- R2: Reception needs continuous receive = 1. The single-receive bit (control bit 5) has no effect: with continuous receive = 0 and single-receive = 1, nothing is received.
- R3: A data bit is taken on each falling edge of the shift clock, least significant bit first. Eight edges make one character in 8-bit mode.
- R4: In nine-bit mode (control bit 6) a character is 9 bits long. Its ninth bit reads in control bit 0 and its low 8 bits read from the data register. In 8-bit mode control bit 0 reads 0.
- R5: The queue holds 2 characters and returns them in arrival order. Receive-complete (status bit 0) is 1 exactly while the queue is not empty. Each data register read removes one entry.
- R6: A character that completes while the queue is full sets overrun (control bit 2) and is discarded. While overrun is 1, no further characters are shifted in.
- R7: Overrun clears when continuous receive is written 0 and stays set otherwise, including across data reads.
- R8: With address filter = 1, a character whose ninth bit is 0 is dropped. A character whose ninth bit is 1 is stored. In 8-bit mode the ninth bit counts as 0.
- R9: The interrupt request is 1 when receive-complete and the interrupt enable (mode bit 2) are both 1. The wake output is 1 when the interrupt request condition holds and the sleep input is 1.
- R10: Writing port enable = 0 resets the bit counter, empties the queue and clears overrun and receive-complete.
- R11: After reset all registers read 0 and the interrupt request and wake outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Shift clock from the external master |
| sdata_in | input | 1 | Serial data line |
| sleep_in | input | 1 | Core is sleeping |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered one cycle after the read |
| irq | output | 1 | Receive interrupt request |
| wake | output | 1 | Wake request while sleeping |

## Verification
The bench builds the block with its default values: 8 data bits plus the ninth bit, a queue depth of 2 and a two-stage synchronizer. The shallow queue makes overrun reachable after only three characters. That lets the bench cover the full-queue discard, the blocking of later characters and the clear through continuous receive within a short run. The bench holds the shift clock four system clocks in each phase, so every falling edge clears the synchronizer before the next data bit changes.

// File: rtl/sslv_pkg.sv
package sslv_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic port_en;
    logic nine_bit;
    logic single_rx;
    logic cont_rx;
    logic addr_filt;
  } ctrl_t;

  typedef struct packed {
    logic rx_ie;
    logic clk_src;
    logic sync_sel;
  } mode_t;
endpackage

// File: rtl/sslv_edge_sync.sv
module sslv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic fall,
  output logic data
);
  logic [STAGES-1:0] sclk_sh, data_sh;
  logic              sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sh   <= '1;
      data_sh   <= '0;
      sclk_prev <= 1'b1;
    end else begin
      sclk_sh   <= {sclk_sh[STAGES-2:0], sclk_in};
      data_sh   <= {data_sh[STAGES-2:0], sdata_in};
      sclk_prev <= sclk_sh[STAGES-1];
    end
  end

  assign fall = sclk_prev & ~sclk_sh[STAGES-1];
  assign data = data_sh[STAGES-1];

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/sslv_shifter.sv
module sslv_shifter #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            nine_bit,
  input  logic            sample,
  input  logic            din,
  output logic            char_valid,
  output logic [DATA_W:0] char_data
);
  localparam int DW = DATA_W + 1;
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sr, sr_nx;
  logic [CW-1:0] cnt, last;

  assign last = nine_bit ? CW'(DW - 1) : CW'(DW - 2);

  always_comb begin
    sr_nx      = sr;
    sr_nx[cnt] = din;
    if (!nine_bit) sr_nx[DW-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt        <= '0;
      char_valid <= 1'b0;
      if (rst) begin
        sr        <= '0;
        char_data <= '0;
      end
    end else begin
      char_valid <= 1'b0;
      if (sample) begin
        sr <= sr_nx;
        if (cnt == last) begin
          cnt        <= '0;
          char_valid <= 1'b1;
          char_data  <= sr_nx;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(DW));
endmodule

// File: rtl/sslv_fifo.sv
module sslv_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CNTW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rp];
  assign empty = (count == '0);
  assign full  = (count == CNTW'(DEPTH));

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH));
  // R5
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sslv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_in,
  input  logic       sdata_in,
  input  logic       sleep_in,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       wake
);
  localparam int CHW = DATA_W + 1;

  ctrl_t            ctrl;
  mode_t            mode;
  logic             ovr;
  logic             fall, sdin, active;
  logic             char_valid, keep, push, pop, empty, full;
  logic [CHW-1:0]   char_data, head;
  logic             head9;

  assign active = ctrl.port_en & mode.sync_sel & ~mode.clk_src & ctrl.cont_rx & ~ovr;

  sslv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .fall(fall), .data(sdin)
  );

  sslv_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(active), .nine_bit(ctrl.nine_bit),
    .sample(fall), .din(sdin), .char_valid(char_valid), .char_data(char_data)
  );

  assign keep = ~(ctrl.addr_filt & ~char_data[CHW-1]);
  assign push = char_valid & keep & ~full;
  assign pop  = rd_en & (addr == A_DATA) & ~empty;

  sslv_fifo #(.W(CHW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(~ctrl.port_en), .push(push), .din(char_data),
    .pop(pop), .head(head), .empty(empty), .full(full)
  );

  assign head9 = ~empty & head[CHW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      mode <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl <= wdata[7:3];
      if (addr == A_MODE) mode <= wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl.port_en || !ctrl.cont_rx) ovr <= 1'b0;
    else if (char_valid && keep && full)      ovr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
      wake  <= 1'b0;
    end else begin
      irq  <= ~empty & mode.rx_ie;
      wake <= ~empty & mode.rx_ie & sleep_in;
      if (rd_en) begin
        case (addr)
          A_CTRL:  rdata <= {ctrl, ovr, 1'b0, head9};
          A_MODE:  rdata <= {5'd0, mode};
          A_DATA:  rdata <= empty ? 8'h00 : head[7:0];
          default: rdata <= {6'd0, irq, ~empty};
        endcase
      end
    end
  end

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ovr && ctrl.port_en && ctrl.cont_rx |=> ovr);
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.port_en |=> empty);
  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mode.rx_ie));
  // R9
  wake_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(sleep_in) && irq);
endmodule

// File: tb/tb_sync_slave_rx.sv
module tb_sync_slave_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  // {nine_bit, addr_filt, expect_kept, word[8:0]}
  localparam logic [11:0] VEC [6] = '{12'h2A5, 12'h23C, 12'hBF0, 12'hA0F, 12'hC55, 12'hFAA};

  logic clk = 1'b0, rst = 1'b1;
  logic sclk_in = 1'b1, sdata_in = 1'b0, sleep_in = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, wake;
  int errors = 0, checks = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_slave_rx dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sleep_in(sleep_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic send(input logic [8:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sdata_in = w[i]; sclk_in = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
      sclk_in = 1'b0;
      repeat (HALF_BIT) @(negedge clk);
    end
    sclk_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    rd(2'd0, rv); check("R11 ctrl", 9'(rv), 9'h000);
    rd(2'd1, rv); check("R11 mode", 9'(rv), 9'h000);
    rd(2'd3, rv); check("R11 stat", 9'(rv), 9'h000);
    check("R11 irq/wake", {7'd0, irq, wake}, 9'h000);

    // R1: clock-source select set blocks reception
    wr(2'd1, 8'h03); wr(2'd0, 8'h90);
    send(9'h0C3, 8);
    rd(2'd3, rv); check("R1 master sel", 9'(rv[0]), 9'h0);
    // R1: sync select clear blocks reception
    wr(2'd1, 8'h00);
    send(9'h0C3, 8);
    rd(2'd3, rv); check("R1 sync clear", 9'(rv[0]), 9'h0);

    // R2: single-receive alone has no effect
    wr(2'd1, 8'h01); wr(2'd0, 8'hA0);
    send(9'h05A, 8);
    rd(2'd3, rv); check("R2 single ignored", 9'(rv[0]), 9'h0);

    // vector table: R3 R4 R8
    foreach (VEC[k]) begin
      wr(2'd0, {1'b1, VEC[k][11], 1'b0, 1'b1, VEC[k][10], 3'b000});
      send(VEC[k][8:0], VEC[k][11] ? 9 : 8);
      rd(2'd3, rv); check("R8 kept", 9'(rv[0]), 9'(VEC[k][9]));
      if (VEC[k][9]) begin
        rd(2'd0, rv); check("R4 ninth bit", 9'(rv[0]), 9'(VEC[k][11] & VEC[k][8]));
        rd(2'd2, rv); check("R3 data", 9'(rv), 9'(VEC[k][7:0]));
        rd(2'd3, rv); check("R5 empty after pop", 9'(rv[0]), 9'h0);
      end
    end

    // R5/R6: fill queue, overrun on third
    wr(2'd0, 8'h90);
    send(9'h011, 8); send(9'h022, 8);
    rd(2'd0, rv); check("R6 no ovr at full", 9'(rv[2]), 9'h0);
    send(9'h033, 8);
    rd(2'd0, rv); check("R6 ovr set", 9'(rv[2]), 9'h1);
    rd(2'd2, rv); check("R5 order first", 9'(rv), 9'h011);
    rd(2'd3, rv); check("R5 still ready", 9'(rv[0]), 9'h1);
    send(9'h044, 8);
    rd(2'd2, rv); check("R5 order second", 9'(rv), 9'h022);
    rd(2'd3, rv); check("R6 blocked no char", 9'(rv[0]), 9'h0);
    rd(2'd0, rv); check("R7 ovr persists", 9'(rv[2]), 9'h1);
    // R7 clear via continuous receive
    wr(2'd0, 8'h80);
    rd(2'd0, rv); check("R7 ovr cleared", 9'(rv[2]), 9'h0);
    wr(2'd0, 8'h90);
    send(9'h066, 8);
    rd(2'd2, rv); check("R7 receive resumes", 9'(rv), 9'h066);

    // R9 interrupt and wake
    wr(2'd1, 8'h05);
    send(9'h077, 8);
    check("R9 irq", 9'(irq), 9'h1);
    check("R9 wake awake", 9'(wake), 9'h0);
    sleep_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 wake asleep", 9'(wake), 9'h1);
    rd(2'd2, rv);
    repeat (2) @(negedge clk);
    check("R9 irq drops", {7'd0, irq, wake}, 9'h000);
    sleep_in = 1'b0;

    // R10 port disable flushes
    send(9'h088, 8);
    wr(2'd0, 8'h10);
    wr(2'd0, 8'h90);
    rd(2'd3, rv); check("R10 flushed", 9'(rv[0]), 9'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule